// File: doc/BRIEF.md
# Multi-Width Transmit Write Aggregator

This block is the user-facing write front end of a packet transmit buffer made of four memory banks. A mode, captured while reset is held, groups the banks into write lanes: four 32-bit lanes, two 64-bit lanes, one 128-bit lane, or a 64-bit lane on banks 0 and 1 beside two 32-bit lanes on banks 2 and 3. Each lane gathers its beats into a 16-byte line and writes the finished line into a 16-line region owned by the addressed port. Each port has its own write pointer, which wraps inside that region.

A line is written on the last beat of its 16-byte period, or earlier when end-of-packet is flagged. A line with no byte enable set is discarded, and a write to a full port is dropped and recorded. Each lane returns the fill status of the port it addresses, with or without a write. Per-port pointer resets and per-bank link disables let the user rewind a port and tell the downstream poller which banks to skip.

Top module: `tx_wr_agg`

## Requirements
- R1: Mode encoding on `mode_i`, captured while `rst_n` is low: 0 gives four 32-bit lanes (lane j uses data word j). 1 gives lanes 0 and 2 at 64 bits, using words {0,1} and {2,3}. 2 gives lane 0 at 128 bits, using all four words. 3 gives lane 0 at 64 bits on words {0,1}, with lanes 2 and 3 at 32 bits. Word k is `wr_data_i[32k+31:32k]` with byte enables `wr_be_i[4k+3:4k]`. A lane takes its control from its own lane index.
- R2: A line takes 4, 2 or 1 beats for a 32-, 64- or 128-bit lane. Beat b places the lane's data at line bits starting at b*width and its enables at the matching byte positions. The port address of the line is the one presented on its first beat.
- R3: A beat with `wr_eop_i` set ends the line early. Bytes that were not delivered carry zero enables, and the lane's next beat starts a new line.
- R4: A completed line whose 16 enables are all zero is not written, and the port pointer does not move.
- R5: A written line appears on the lane's memory write port one cycle after the completing beat. Its address is port*16 plus the low 4 bits of the port's 5-bit write pointer, which then increments and wraps every 16 lines.
- R6: When a lane sees `addr_vld_i` or `wr_en_i`, then on the next cycle `st_vld_o` is high and `st_code_o` gives the fill state of the addressed port before this cycle's write. The fill is the write pointer minus `rd_ptr_i`, modulo 32. The code is 0 for empty, 1 below 8, 2 from 8 to 15, and 3 at 16 or more.
- R7: A completed line with enables, addressed to a port whose fill is 16 or more, is dropped. The lane's `ovf_o` then goes high and stays high until reset.
- R8: `ptr_rst_i` bit j*4+p clears the write pointer of port p in lane j. It takes precedence over a write to that port in the same cycle.
- R9: `svc_en_o[b]` is low whenever any bank grouped with bank b by the current mode has `link_dis_i` set.
- R10: Lanes that the mode leaves unused never write or report status. A change on `mode_i` after reset has no effect.
- R11: During reset, `line_we_o`, `st_vld_o` and `ovf_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Bank grouping, captured during reset |
| wr_en_i | input | 4 | Write beat strobe per lane |
| addr_vld_i | input | 4 | Status query strobe per lane |
| wr_port_i | input | 8 | Port address per lane, 2 bits each |
| wr_eop_i | input | 4 | End of packet per lane |
| wr_data_i | input | 128 | Four 32-bit data words |
| wr_be_i | input | 16 | Byte enables for the data words |
| ptr_rst_i | input | 16 | Write-pointer clear per lane and port |
| rd_ptr_i | input | 80 | Consumer read pointer, 5 bits per lane and port |
| link_dis_i | input | 4 | Per-bank link disable |
| line_we_o | output | 4 | Line write strobe per lane |
| line_addr_o | output | 24 | Line address per lane, 6 bits each |
| line_data_o | output | 512 | Line data per lane, 128 bits each |
| line_be_o | output | 64 | Line byte enables per lane, 16 bits each |
| st_vld_o | output | 4 | Status valid per lane |
| st_code_o | output | 8 | Fill code per lane, 2 bits each |
| ovf_o | output | 4 | Sticky overflow per lane |
| svc_en_o | output | 4 | Bank may be serviced by the poller |

## Verification
Two events can land in the same cycle: a line commit on a port and a clear of that same port's write pointer. The directed case sends an end-of-packet beat with enables set and the port's clear bit in one cycle. It then expects the line to be written at the old pointer. A status query on the next cycle must then report empty against a read pointer of zero. Random traffic also raises clear bits beside beats and queries, and a cycle-level model written from the requirements judges every lane on every cycle.

// File: rtl/tx_wagg_pkg.sv
package tx_wagg_pkg;

  localparam int NUM_LANES = 4;

  typedef enum logic [1:0] {
    AGG_4X32  = 2'd0,
    AGG_2X64  = 2'd1,
    AGG_1X128 = 2'd2,
    AGG_MIX   = 2'd3
  } agg_mode_e;

  // Number of 32-bit words a lane consumes per beat; zero when unused.
  function automatic logic [2:0] lane_chunks(agg_mode_e m, int lane);
    logic [2:0] c;
    c = 3'd0;
    case (m)
      AGG_4X32:  c = 3'd1;
      AGG_2X64:  c = (lane == 0 || lane == 2) ? 3'd2 : 3'd0;
      AGG_1X128: c = (lane == 0) ? 3'd4 : 3'd0;
      AGG_MIX:   c = (lane == 0) ? 3'd2 : ((lane == 1) ? 3'd0 : 3'd1);
      default:   c = 3'd0;
    endcase
    return c;
  endfunction

  // Banks that share a lane with the given bank.
  function automatic logic [NUM_LANES-1:0] bank_group(agg_mode_e m, int bank);
    logic [NUM_LANES-1:0] own;
    logic [NUM_LANES-1:0] grp;
    own = NUM_LANES'(1) << bank;
    case (m)
      AGG_4X32:  grp = own;
      AGG_2X64:  grp = (bank < 2) ? 4'b0011 : 4'b1100;
      AGG_1X128: grp = 4'b1111;
      AGG_MIX:   grp = (bank < 2) ? 4'b0011 : own;
      default:   grp = own;
    endcase
    return grp;
  endfunction

endpackage

// File: rtl/tx_wagg_svc.sv
module tx_wagg_svc
  import tx_wagg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  agg_mode_e            mode_i,
  input  logic [NUM_LANES-1:0] link_dis_i,
  output logic [NUM_LANES-1:0] svc_en_o
);

  for (genvar b = 0; b < NUM_LANES; b++) begin : g_bank
    assign svc_en_o[b] = ~|(link_dis_i & bank_group(mode_i, b));

    // R9: a disabled bank is never offered to the poller
    a_r9_dis_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      link_dis_i[b] |-> !svc_en_o[b]);
  end

endmodule

// File: rtl/tx_wagg_lane.sv
module tx_wagg_lane
  import tx_wagg_pkg::*;
#(
  parameter int LANE_W    = 32,
  parameter int NUM_PORTS = 4,
  parameter int LINES     = 16,
  localparam int LINE_W   = NUM_LANES * LANE_W,
  localparam int LINE_B   = LINE_W / 8,
  localparam int LANE_B   = LANE_W / 8,
  localparam int PW       = $clog2(NUM_PORTS),
  localparam int LW       = $clog2(LINES),
  localparam int PTR_W    = LW + 1,
  localparam int AW       = PW + LW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 chunks_i,
  input  logic                       wr_en_i,
  input  logic                       addr_vld_i,
  input  logic [PW-1:0]              port_i,
  input  logic                       eop_i,
  input  logic [LINE_W-1:0]          data_i,
  input  logic [LINE_B-1:0]          be_i,
  input  logic [NUM_PORTS-1:0]       ptr_rst_i,
  input  logic [NUM_PORTS*PTR_W-1:0] rd_ptr_i,
  output logic                       line_we_o,
  output logic [AW-1:0]              line_addr_o,
  output logic [LINE_W-1:0]          line_data_o,
  output logic [LINE_B-1:0]          line_be_o,
  output logic                       st_vld_o,
  output logic [1:0]                 st_code_o,
  output logic                       ovf_o
);

  localparam int HALF = LINES / 2;

  function automatic logic [1:0] fill_code(logic [PTR_W-1:0] f);
    if (f == '0)                     return 2'd0;
    else if (int'(f) >= LINES)       return 2'd3;
    else if (int'(f) >= HALF)        return 2'd2;
    else                             return 2'd1;
  endfunction

  // state
  logic [1:0]        beat_q, beat_d;
  logic [PW-1:0]     port_q;
  logic [LINE_W-1:0] stg_data_q;
  logic [LINE_B-1:0] stg_be_q;
  logic [PTR_W-1:0]  wptr_q [NUM_PORTS];
  logic [PTR_W-1:0]  wptr_d [NUM_PORTS];
  logic              ovf_q, ovf_d;

  // datapath
  logic              active;
  logic [1:0]        beats_m1;
  logic [LINE_W-1:0] data_mask, acc_data;
  logic [LINE_B-1:0] be_mask, acc_be;
  int unsigned       shift_units;
  logic              first, last, commit, has_be, full, do_write, drop, stage_en;
  logic [PW-1:0]     port_use;
  logic [PTR_W-1:0]  fill [NUM_PORTS];

  // output next values
  logic              st_vld_d;
  logic [1:0]        st_code_d;
  logic [AW-1:0]     addr_d;

  assign active = (chunks_i != 3'd0);

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      fill[p] = wptr_q[p] - rd_ptr_i[p*PTR_W +: PTR_W];
    end
  end

  always_comb begin
    case (chunks_i)
      3'd1:    beats_m1 = 2'd3;
      3'd2:    beats_m1 = 2'd1;
      default: beats_m1 = 2'd0;
    endcase
    data_mask   = {LINE_W{1'b1}} >> ((NUM_LANES - int'(chunks_i)) * LANE_W);
    be_mask     = {LINE_B{1'b1}} >> ((NUM_LANES - int'(chunks_i)) * LANE_B);
    shift_units = 32'(beat_q) * 32'(chunks_i);
    first       = (beat_q == 2'd0);
    port_use    = first ? port_i : port_q;
    acc_data    = (first ? '0 : stg_data_q) | ((data_i & data_mask) << (shift_units * LANE_W));
    acc_be      = (first ? '0 : stg_be_q) | ((be_i & be_mask) << (shift_units * LANE_B));
    last        = eop_i || (beat_q == beats_m1);
    commit      = active && wr_en_i && last;
    stage_en    = active && wr_en_i && !last;
    has_be      = |acc_be;
    full        = (int'(fill[port_use]) >= LINES);
    do_write    = commit && has_be && !full;
    drop        = commit && has_be && full;
    addr_d      = {port_use, wptr_q[port_use][LW-1:0]};
    st_vld_d    = active && (wr_en_i || addr_vld_i);
    st_code_d   = fill_code(fill[port_i]);
    ovf_d       = ovf_q | drop;
    if (commit)        beat_d = 2'd0;
    else if (stage_en) beat_d = beat_q + 2'd1;
    else               beat_d = beat_q;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (ptr_rst_i[p])                        wptr_d[p] = '0;
      else if (do_write && port_use == PW'(p)) wptr_d[p] = wptr_q[p] + 1'b1;
      else                                     wptr_d[p] = wptr_q[p];
    end
  end

  // staging and pointers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q     <= '0;
      port_q     <= '0;
      stg_data_q <= '0;
      stg_be_q   <= '0;
      ovf_q      <= 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) wptr_q[p] <= '0;
    end else begin
      beat_q <= beat_d;
      ovf_q  <= ovf_d;
      if (stage_en) begin
        port_q     <= port_use;
        stg_data_q <= acc_data;
        stg_be_q   <= acc_be;
      end
      for (int p = 0; p < NUM_PORTS; p++) wptr_q[p] <= wptr_d[p];
    end
  end

  // memory write port and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_we_o   <= 1'b0;
      line_addr_o <= '0;
      line_data_o <= '0;
      line_be_o   <= '0;
      st_vld_o    <= 1'b0;
      st_code_o   <= '0;
    end else begin
      line_we_o <= do_write;
      st_vld_o  <= st_vld_d;
      if (do_write) begin
        line_addr_o <= addr_d;
        line_data_o <= acc_data;
        line_be_o   <= acc_be;
      end
      if (st_vld_d) st_code_o <= st_code_d;
    end
  end

  assign ovf_o = ovf_q;

  // R4: nothing reaches memory without at least one enable
  a_r4_we_has_be: assert property (@(posedge clk) disable iff (!rst_n)
    line_we_o |-> (|line_be_o));

  // R7: overflow flag never falls outside reset
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  // R6: a query or beat on a used lane yields status next cycle
  a_r6_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (wr_en_i || addr_vld_i)) |=> st_vld_o);

  // R10: an unused lane stays silent
  a_r10_idle_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!line_we_o && !st_vld_o));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
    // R8: a pointer clear always lands
    a_r8_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_rst_i[p] |=> (wptr_q[p] == '0));
    // R5: a pointer only holds, steps by one, or is cleared
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wptr_q[p] == $past(wptr_q[p])) || (wptr_q[p] == $past(wptr_q[p]) + 1'b1)
      || (wptr_q[p] == '0));
  end

endmodule

// File: rtl/tx_wr_agg.sv
module tx_wr_agg
  import tx_wagg_pkg::*;
#(
  parameter int LANE_W    = 32,
  parameter int NUM_PORTS = 4,
  parameter int LINES     = 16,
  localparam int LINE_W   = NUM_LANES * LANE_W,
  localparam int LINE_B   = LINE_W / 8,
  localparam int PW       = $clog2(NUM_PORTS),
  localparam int PTR_W    = $clog2(LINES) + 1,
  localparam int AW       = PW + $clog2(LINES)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [1:0]                           mode_i,
  input  logic [NUM_LANES-1:0]                 wr_en_i,
  input  logic [NUM_LANES-1:0]                 addr_vld_i,
  input  logic [NUM_LANES*PW-1:0]              wr_port_i,
  input  logic [NUM_LANES-1:0]                 wr_eop_i,
  input  logic [LINE_W-1:0]                    wr_data_i,
  input  logic [LINE_B-1:0]                    wr_be_i,
  input  logic [NUM_LANES*NUM_PORTS-1:0]       ptr_rst_i,
  input  logic [NUM_LANES*NUM_PORTS*PTR_W-1:0] rd_ptr_i,
  input  logic [NUM_LANES-1:0]                 link_dis_i,
  output logic [NUM_LANES-1:0]                 line_we_o,
  output logic [NUM_LANES*AW-1:0]              line_addr_o,
  output logic [NUM_LANES*LINE_W-1:0]          line_data_o,
  output logic [NUM_LANES*LINE_B-1:0]          line_be_o,
  output logic [NUM_LANES-1:0]                 st_vld_o,
  output logic [NUM_LANES*2-1:0]               st_code_o,
  output logic [NUM_LANES-1:0]                 ovf_o,
  output logic [NUM_LANES-1:0]                 svc_en_o
);

  agg_mode_e mode_q;

  // Mode is captured only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= agg_mode_e'(mode_i);
  end

  // R10: grouping cannot change outside reset
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q));

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    logic [2:0]        chunks;
    logic [LINE_W-1:0] data_al;
    logic [LINE_B-1:0] be_al;

    assign chunks  = lane_chunks(mode_q, j);
    assign data_al = wr_data_i >> (j * LANE_W);
    assign be_al   = wr_be_i >> (j * (LANE_W / 8));

    tx_wagg_lane #(
      .LANE_W    (LANE_W),
      .NUM_PORTS (NUM_PORTS),
      .LINES     (LINES)
    ) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .chunks_i    (chunks),
      .wr_en_i     (wr_en_i[j]),
      .addr_vld_i  (addr_vld_i[j]),
      .port_i      (wr_port_i[j*PW +: PW]),
      .eop_i       (wr_eop_i[j]),
      .data_i      (data_al),
      .be_i        (be_al),
      .ptr_rst_i   (ptr_rst_i[j*NUM_PORTS +: NUM_PORTS]),
      .rd_ptr_i    (rd_ptr_i[j*NUM_PORTS*PTR_W +: NUM_PORTS*PTR_W]),
      .line_we_o   (line_we_o[j]),
      .line_addr_o (line_addr_o[j*AW +: AW]),
      .line_data_o (line_data_o[j*LINE_W +: LINE_W]),
      .line_be_o   (line_be_o[j*LINE_B +: LINE_B]),
      .st_vld_o    (st_vld_o[j]),
      .st_code_o   (st_code_o[j*2 +: 2]),
      .ovf_o       (ovf_o[j])
    );
  end

  tx_wagg_svc u_svc (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_q),
    .link_dis_i (link_dis_i),
    .svc_en_o   (svc_en_o)
  );

endmodule

// File: tb/tx_wr_agg_tb_top.sv
module tx_wr_agg_tb_top;

  logic         clk;
  logic         rst_n;
  logic [1:0]   mode_i;
  logic [3:0]   wr_en_i, addr_vld_i, wr_eop_i, link_dis_i;
  logic [7:0]   wr_port_i;
  logic [127:0] wr_data_i;
  logic [15:0]  wr_be_i;
  logic [15:0]  ptr_rst_i;
  logic [79:0]  rd_ptr_i;
  logic [3:0]   line_we_o, st_vld_o, ovf_o, svc_en_o;
  logic [23:0]  line_addr_o;
  logic [511:0] line_data_o;
  logic [63:0]  line_be_o;
  logic [7:0]   st_code_o;

  tx_wr_agg dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_en_i(wr_en_i),
    .addr_vld_i(addr_vld_i), .wr_port_i(wr_port_i), .wr_eop_i(wr_eop_i),
    .wr_data_i(wr_data_i), .wr_be_i(wr_be_i), .ptr_rst_i(ptr_rst_i),
    .rd_ptr_i(rd_ptr_i), .link_dis_i(link_dis_i), .line_we_o(line_we_o),
    .line_addr_o(line_addr_o), .line_data_o(line_data_o), .line_be_o(line_be_o),
    .st_vld_o(st_vld_o), .st_code_o(st_code_o), .ovf_o(ovf_o), .svc_en_o(svc_en_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  // model state
  logic [1:0]   b_mode;
  int           m_beat [4];
  logic [1:0]   m_port [4];
  logic [127:0] m_ld   [4];
  logic [15:0]  m_lb   [4];
  logic [4:0]   m_w    [4][4];
  logic [4:0]   m_r    [4][4];
  logic         m_ovf  [4];
  // expected registered outputs
  logic         e_we   [4];
  logic [5:0]   e_addr [4];
  logic [127:0] e_data [4];
  logic [15:0]  e_be   [4];
  logic         e_stv  [4];
  logic [1:0]   e_st   [4];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int chunks_of(logic [1:0] m, int j);
    case (m)
      2'd0: return 1;
      2'd1: return (j == 0 || j == 2) ? 2 : 0;
      2'd2: return (j == 0) ? 4 : 0;
      default: return (j == 0) ? 2 : ((j == 1) ? 0 : 1);
    endcase
  endfunction

  function automatic logic [3:0] svc_exp(logic [1:0] m, logic [3:0] dis);
    logic [3:0] s;
    case (m)
      2'd0: s = ~dis;
      2'd1: s = {{2{~|dis[3:2]}}, {2{~|dis[1:0]}}};
      2'd2: s = {4{~|dis}};
      default: s = {~dis[3], ~dis[2], {2{~|dis[1:0]}}};
    endcase
    return s;
  endfunction

  function automatic logic [1:0] code_of(logic [4:0] f);
    if (f == 0) return 2'd0;
    if (f >= 16) return 2'd3;
    if (f >= 8) return 2'd2;
    return 2'd1;
  endfunction

  task automatic clear_inputs();
    wr_en_i = 0; addr_vld_i = 0; wr_eop_i = 0; link_dis_i = 0;
    wr_port_i = 0; wr_data_i = 0; wr_be_i = 0; ptr_rst_i = 0;
  endtask

  task automatic compare();
    for (int j = 0; j < 4; j++) begin
      string t;
      t = (chunks_of(b_mode, j) == 0) ? "R10" : cur_tag;
      chk(line_we_o[j] == e_we[j], t, "line_we", line_we_o[j], e_we[j]);
      if (e_we[j] && line_we_o[j]) begin
        chk(line_addr_o[j*6 +: 6] == e_addr[j], "R5", "line_addr", line_addr_o[j*6 +: 6], e_addr[j]);
        chk(line_data_o[j*128 +: 128] == e_data[j], t, "line_data", line_data_o[j*128 +: 128], e_data[j]);
        chk(line_be_o[j*16 +: 16] == e_be[j], t, "line_be", line_be_o[j*16 +: 16], e_be[j]);
      end
      chk(st_vld_o[j] == e_stv[j], t, "st_vld", st_vld_o[j], e_stv[j]);
      if (e_stv[j] && st_vld_o[j])
        chk(st_code_o[j*2 +: 2] == e_st[j], "R6", "st_code", st_code_o[j*2 +: 2], e_st[j]);
      chk(ovf_o[j] == m_ovf[j], "R7", "ovf", ovf_o[j], m_ovf[j]);
    end
  endtask

  // One clock: inputs are already set; model the edge, then compare.
  task automatic step();
    for (int j = 0; j < 4; j++)
      for (int p = 0; p < 4; p++) rd_ptr_i[(j*4+p)*5 +: 5] = m_r[j][p];
    #1;
    chk(svc_en_o == svc_exp(b_mode, link_dis_i), "R9", "svc_en", svc_en_o, svc_exp(b_mode, link_dis_i));
    for (int j = 0; j < 4; j++) begin
      int c, bm1;
      logic [127:0] msk, chunk, ld;
      logic [15:0] bmsk, bch, lb;
      logic [1:0] pi, pu;
      logic [4:0] fsel;
      bit last;
      c = chunks_of(b_mode, j);
      e_we[j] = 0;
      e_stv[j] = 0;
      if (c != 0) begin
        pi = wr_port_i[j*2 +: 2];
        e_stv[j] = wr_en_i[j] | addr_vld_i[j];
        if (e_stv[j]) e_st[j] = code_of(m_w[j][pi] - m_r[j][pi]);
        if (wr_en_i[j]) begin
          msk  = (c == 4) ? {128{1'b1}} : (c == 2) ? {64'd0, {64{1'b1}}} : {96'd0, {32{1'b1}}};
          bmsk = (c == 4) ? 16'hFFFF : (c == 2) ? 16'h00FF : 16'h000F;
          chunk = (wr_data_i >> (j*32)) & msk;
          bch   = (wr_be_i >> (j*4)) & bmsk;
          bm1 = (c == 1) ? 3 : (c == 2) ? 1 : 0;
          pu = (m_beat[j] == 0) ? pi : m_port[j];
          ld = ((m_beat[j] == 0) ? 128'd0 : m_ld[j]) | (chunk << (m_beat[j]*c*32));
          lb = ((m_beat[j] == 0) ? 16'd0 : m_lb[j]) | (bch << (m_beat[j]*c*4));
          last = wr_eop_i[j] || (m_beat[j] == bm1);
          if (last) begin
            fsel = m_w[j][pu] - m_r[j][pu];
            if (lb != 0) begin
              if (fsel >= 16) m_ovf[j] = 1;
              else begin
                e_we[j] = 1; e_addr[j] = {pu, m_w[j][pu][3:0]};
                e_data[j] = ld; e_be[j] = lb;
                m_w[j][pu] = m_w[j][pu] + 1;
              end
            end
            m_beat[j] = 0;
          end else begin
            m_beat[j] = m_beat[j] + 1; m_port[j] = pu; m_ld[j] = ld; m_lb[j] = lb;
          end
        end
      end
      for (int p = 0; p < 4; p++) if (ptr_rst_i[j*4+p]) m_w[j][p] = 0;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 0;
    mode_i = m;
    clear_inputs();
    rd_ptr_i = 0;
    repeat (3) @(negedge clk);
    for (int j = 0; j < 4; j++) begin
      chk(line_we_o[j] == 0 && st_vld_o[j] == 0 && ovf_o[j] == 0, "R11", "reset outputs",
          {line_we_o[j], st_vld_o[j], ovf_o[j]}, 0);
      m_beat[j] = 0; m_port[j] = 0; m_ld[j] = 0; m_lb[j] = 0; m_ovf[j] = 0;
      for (int p = 0; p < 4; p++) begin m_w[j][p] = 0; m_r[j][p] = 0; end
    end
    b_mode = m;
    rst_n = 1;
    mode_i = ~m;   // R10: ignored after reset
  endtask

  task automatic rnd_cycle();
    clear_inputs();
    for (int j = 0; j < 4; j++) begin
      wr_en_i[j]    = ($urandom % 3) != 0;
      addr_vld_i[j] = ($urandom % 4) == 0;
      wr_eop_i[j]   = ($urandom % 6) == 0;
      wr_port_i[j*2 +: 2] = 2'($urandom);
      wr_data_i[j*32 +: 32] = $urandom;
      wr_be_i[j*4 +: 4] = (($urandom % 5) == 0) ? 4'd0 : 4'($urandom);
      link_dis_i[j] = ($urandom % 4) == 0;
      for (int p = 0; p < 4; p++) begin
        if (($urandom % 50) == 0) begin
          ptr_rst_i[j*4+p] = 1'b1;
          m_r[j][p] = 0;
        end else if (m_w[j][p] != m_r[j][p] && ($urandom % 7) == 0) begin
          m_r[j][p] = m_r[j][p] + 1;
        end
      end
    end
    step();
  endtask

  task automatic wr128(input logic [1:0] port, input logic [15:0] be, input logic eop);
    clear_inputs();
    wr_en_i[0] = 1; wr_port_i[1:0] = port; wr_be_i = be; wr_eop_i[0] = eop;
    wr_data_i = {$urandom, $urandom, $urandom, $urandom};
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0;
    clear_inputs();
    rd_ptr_i = 0;
    mode_i = 0;

    // R1/R9/R10 random traffic in every grouping
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      cur_tag = "R1";
      for (int n = 0; n < 1200; n++) rnd_cycle();
    end

    // R2: four 32-bit beats assemble one line on lane 1
    do_reset(2'd0);
    cur_tag = "R2";
    for (int b = 0; b < 4; b++) begin
      clear_inputs();
      wr_en_i[1] = 1; wr_port_i[3:2] = 2'd3; wr_be_i[7:4] = 4'hF;
      wr_data_i[63:32] = 32'h11111111 * (b + 1);
      if (b == 1) wr_port_i[3:2] = 2'd0;   // port of later beats is ignored
      step();
    end
    chk(line_we_o[1] && line_data_o[255:128] == 128'h44444444_33333333_22222222_11111111,
        "R2", "assembled line", line_data_o[255:128], 128'h44444444_33333333_22222222_11111111);
    chk(line_addr_o[11:6] == 6'd48, "R2", "first-beat port", line_addr_o[11:6], 6'd48);

    // R3: early end of packet on lane 2
    cur_tag = "R3";
    clear_inputs();
    wr_en_i[2] = 1; wr_eop_i[2] = 1; wr_port_i[5:4] = 2'd2; wr_be_i[11:8] = 4'h6;
    wr_data_i[95:64] = 32'hCAFE0001;
    step();
    chk(line_we_o[2] && line_be_o[47:32] == 16'h0006, "R3", "eop partial line",
        {line_we_o[2], line_be_o[47:32]}, {1'b1, 16'h0006});

    // R4: all-zero enables on a 128-bit line
    do_reset(2'd2);
    cur_tag = "R4";
    wr128(2'd1, 16'h0000, 1'b0);
    step();
    chk(line_we_o[0] == 0, "R4", "empty line suppressed", line_we_o[0], 0);
    wr128(2'd1, 16'h0001, 1'b0);
    step();
    chk(line_addr_o[5:0] == 6'd16, "R4", "pointer unchanged", line_addr_o[5:0], 6'd16);

    // R7: fill port 0 to 16, then one more
    cur_tag = "R7";
    for (int k = 0; k < 17; k++) begin
      wr128(2'd0, 16'hFFFF, 1'b1);
      step();
    end
    chk(line_we_o[0] == 0 && ovf_o[0] == 1, "R7", "drop when full",
        {line_we_o[0], ovf_o[0]}, 2'b01);
    clear_inputs(); addr_vld_i[0] = 1;
    step();
    chk(st_code_o[1:0] == 2'd3, "R6", "full code", st_code_o[1:0], 2'd3);

    // R5: drain and wrap
    cur_tag = "R5";
    m_r[0][0] = 5'd16;
    wr128(2'd0, 16'hFFFF, 1'b1);
    step();
    chk(line_we_o[0] && line_addr_o[5:0] == 6'd0, "R5", "wrapped address",
        {line_we_o[0], line_addr_o[5:0]}, {1'b1, 6'd0});

    // R8: clear and write to the same port in one cycle
    cur_tag = "R8";
    for (int k = 0; k < 3; k++) begin wr128(2'd2, 16'h00F0, 1'b1); step(); end
    wr128(2'd2, 16'h0F00, 1'b1);
    ptr_rst_i[2] = 1'b1;
    m_r[0][2] = 0;
    step();
    chk(line_we_o[0] && line_addr_o[5:0] == 6'd35, "R8", "write at old pointer",
        {line_we_o[0], line_addr_o[5:0]}, {1'b1, 6'd35});
    clear_inputs(); addr_vld_i[0] = 1; wr_port_i[1:0] = 2'd2;
    step();
    chk(st_vld_o[0] && st_code_o[1:0] == 2'd0, "R8", "cleared port empty",
        {st_vld_o[0], st_code_o[1:0]}, 3'b100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule